// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits beside a small 8-bit controller core. It produces the internal reset, the machine-cycle strobe and the clock enables that carry the core through running, idle and power-down. Machine cycles are built from a fixed number of oscillator periods. An external reset pin has to stay high for two whole machine cycles before the internal reset is asserted. While the pin is high, the port latches are driven high at once, before that qualification has finished.

Software enters the low-power states by writing request bits into a power-control register. The write strobe and the two bits come into this block. In idle, only the CPU enable is removed. The peripheral enable and the machine-cycle strobe keep running, and any enabled pending interrupt ends idle. In power-down, the oscillator-run flag drops and every enable stops. Interrupts are ignored in power-down, and only the reset pin brings the block out: raising the pin restarts the oscillator, and the qualified reset then clears the mode. If the reset pin ends idle, the CPU resumes at once and runs until the qualified reset takes hold. During that window a RAM write-block flag is raised, and port writes are left alone.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While the oscillator runs, `mcyc_tick` pulses for one clock in every 12 clocks. The first pulse comes 12 clocks after power-up is released.
- R2: `core_rst` rises on the 24th rising edge that samples `rst_pin` high with no break. A pin pulse shorter than 24 clocks gives no reset, and the count starts again from zero after any low sample.
- R3: `port_force_hi` is high in the same cycle `rst_pin` is high, with no clock edge needed. It stays high while `core_rst` is high.
- R4: One rising edge after `rst_pin` is sampled low, `core_rst` is 0.
- R5: A power-control write with the idle request set and the power-down request clear sets `idle_bit` at the next edge. In idle, `cpu_ce` is 0, `per_ce` is 1 and `mcyc_tick` keeps pulsing.
- R6: In idle, any nonzero `irq_pend` clears `idle_bit` at the next edge, and `cpu_ce` returns to 1.
- R7: A power-control write with the power-down request set sets `pd_bit`. In power-down, `osc_run`, `cpu_ce`, `per_ce` and `mcyc_tick` are all 0, and the machine-cycle counter holds its value.
- R8: In power-down, `irq_pend` has no effect: `pd_bit` stays 1 and `osc_run` stays 0.
- R9: In power-down, `osc_run` goes to 1 as soon as `rst_pin` is high. `pd_bit` stays set until `core_rst` is asserted, and it is 0 one edge after that.
- R10: A single write with both request bits set enters power-down. `pd_bit` is 1 and `idle_bit` is 0.
- R11: In idle, when `rst_pin` is sampled high, `idle_bit` clears at that edge, and `cpu_ce` and `ram_wr_block` are 1 until `core_rst` is asserted. `ram_wr_block` is 0 one edge after `core_rst` rises.
- R12: While `core_rst` is 1, power-control writes are ignored, and `idle_bit` and `pd_bit` both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-up clear, active low, asynchronous |
| rst_pin | input | 1 | External reset pin, active high |
| pcon_wr | input | 1 | Write strobe of the power-control register |
| pcon_idle_req | input | 1 | Idle request bit in the write data |
| pcon_pd_req | input | 1 | Power-down request bit in the write data |
| irq_pend | input | N_IRQ | Enabled pending interrupts, one bit per source |
| core_rst | output | 1 | Qualified internal reset |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator running flag |
| port_force_hi | output | 1 | Forces the port latches to 1 |
| mcyc_tick | output | 1 | One-clock strobe at the end of each machine cycle |
| ram_wr_block | output | 1 | Blocks internal RAM writes in the reset-exit window |
| idle_bit | output | 1 | Idle request bit read back |
| pd_bit | output | 1 | Power-down request bit read back |

## Verification
A corrupt qualification count shows up as `core_rst` rising one or more clocks away from the 24th edge, and the shorter-pulse cases catch that within one pulse. A mode register in the wrong state is visible on the enables and the bit readbacks at the very next edge after the write, interrupt or pin event. A stuck or miscounting machine-cycle counter shows up as the wrong spacing or count of `mcyc_tick` within a few machine cycles, or as pulses during power-down.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    localparam int unsigned MC_CLKS_DEF  = 12;
    localparam int unsigned QUAL_MC_DEF  = 2;
    localparam int unsigned N_IRQ_DEF    = 4;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2
    } pm_mode_e;

endpackage

// File: rtl/pwrmode_mcyc.sv
module pwrmode_mcyc #(
    parameter int unsigned MC_CLKS = pwrmode_pkg::MC_CLKS_DEF
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MC_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } mc_state_t;

    mc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (st_q.cnt == LAST) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = run && (st_q.cnt == LAST);

    AST_MC_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cnt <= LAST);  // R1
    AST_MC_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
        !run |=> $stable(st_q.cnt));  // R7
    AST_MC_WRAP: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> (st_q.cnt == '0));  // R1

endmodule

// File: rtl/pwrmode_rstqual.sv
module pwrmode_rstqual #(
    parameter int unsigned MC_CLKS = pwrmode_pkg::MC_CLKS_DEF,
    parameter int unsigned QUAL_MC = pwrmode_pkg::QUAL_MC_DEF
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic osc_run,
    output logic core_rst
);
    localparam int unsigned QUAL_CLKS = MC_CLKS * QUAL_MC;
    localparam int unsigned QW = $clog2(QUAL_CLKS + 1);
    localparam logic [QW-1:0] QLAST = QW'(QUAL_CLKS - 1);

    typedef struct packed {
        logic [QW-1:0] cnt;
        logic          rst;
    } q_state_t;

    q_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_pin) begin
            st_d.cnt = '0;
            st_d.rst = 1'b0;
        end else if (osc_run) begin
            if (st_q.cnt == QLAST) st_d.rst = 1'b1;
            else                   st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign core_rst = st_q.rst;

    AST_RST_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst) |-> $past(rst_pin));  // R2
    AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin |=> !core_rst);  // R4
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst && rst_pin) |=> core_rst);  // R3

endmodule

// File: rtl/pwrmode_mode.sv
module pwrmode_mode #(
    parameter int unsigned N_IRQ = pwrmode_pkg::N_IRQ_DEF
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             core_rst,
    input  logic             rst_pin,
    input  logic             pcon_wr,
    input  logic             pcon_idle_req,
    input  logic             pcon_pd_req,
    input  logic [N_IRQ-1:0] irq_pend,
    output logic             in_idle,
    output logic             in_pd,
    output logic             ram_block
);
    import pwrmode_pkg::*;

    typedef struct packed {
        pm_mode_e mode;
        logic     rwb;
    } m_state_t;

    m_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_pin) st_d.rwb = 1'b0;
        if (core_rst) begin
            st_d.mode = PM_RUN;
            st_d.rwb  = 1'b0;
        end else begin
            unique case (st_q.mode)
                PM_RUN: begin
                    if (pcon_wr) begin
                        if (pcon_pd_req)        st_d.mode = PM_PDOWN;
                        else if (pcon_idle_req) st_d.mode = PM_IDLE;
                    end
                end
                PM_IDLE: begin
                    if (rst_pin) begin
                        st_d.mode = PM_RUN;
                        st_d.rwb  = 1'b1;
                    end else if (|irq_pend) begin
                        st_d.mode = PM_RUN;
                    end
                end
                PM_PDOWN: st_d.mode = PM_PDOWN;
                default:  st_d.mode = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{mode: PM_RUN, rwb: 1'b0};
        else        st_q <= st_d;
    end

    assign in_idle   = (st_q.mode == PM_IDLE);
    assign in_pd     = (st_q.mode == PM_PDOWN);
    assign ram_block = st_q.rwb;

    AST_PD_NO_IRQ_EXIT: assert property (@(posedge clk) disable iff (!por_n)
        (in_pd && !core_rst) |=> in_pd);  // R8
    AST_RST_CLEARS_MODE: assert property (@(posedge clk) disable iff (!por_n)
        core_rst |=> (!in_idle && !in_pd));  // R12
    AST_RWB_NEEDS_PIN: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin |=> !ram_block);  // R11
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
        $countones({in_idle, in_pd}) <= 1);  // R10

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl #(
    parameter int unsigned MC_CLKS = pwrmode_pkg::MC_CLKS_DEF,
    parameter int unsigned QUAL_MC = pwrmode_pkg::QUAL_MC_DEF,
    parameter int unsigned N_IRQ   = pwrmode_pkg::N_IRQ_DEF
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_pin,
    input  logic             pcon_wr,
    input  logic             pcon_idle_req,
    input  logic             pcon_pd_req,
    input  logic [N_IRQ-1:0] irq_pend,
    output logic             core_rst,
    output logic             cpu_ce,
    output logic             per_ce,
    output logic             osc_run,
    output logic             port_force_hi,
    output logic             mcyc_tick,
    output logic             ram_wr_block,
    output logic             idle_bit,
    output logic             pd_bit
);
    logic in_idle, in_pd, ram_block, rst_q;

    // The reset pin restarts a stopped oscillator.
    assign osc_run       = !in_pd || rst_pin;
    assign per_ce        = !in_pd && !rst_q;
    assign cpu_ce        = per_ce && !in_idle;
    assign port_force_hi = rst_pin || rst_q;
    assign core_rst      = rst_q;
    assign ram_wr_block  = ram_block;
    assign idle_bit      = in_idle;
    assign pd_bit        = in_pd;

    pwrmode_mcyc #(.MC_CLKS(MC_CLKS)) u_mcyc (
        .clk   (clk),
        .por_n (por_n),
        .run   (osc_run),
        .tick  (mcyc_tick)
    );

    pwrmode_rstqual #(.MC_CLKS(MC_CLKS), .QUAL_MC(QUAL_MC)) u_qual (
        .clk      (clk),
        .por_n    (por_n),
        .rst_pin  (rst_pin),
        .osc_run  (osc_run),
        .core_rst (rst_q)
    );

    pwrmode_mode #(.N_IRQ(N_IRQ)) u_mode (
        .clk           (clk),
        .por_n         (por_n),
        .core_rst      (rst_q),
        .rst_pin       (rst_pin),
        .pcon_wr       (pcon_wr),
        .pcon_idle_req (pcon_idle_req),
        .pcon_pd_req   (pcon_pd_req),
        .irq_pend      (irq_pend),
        .in_idle       (in_idle),
        .in_pd         (in_pd),
        .ram_block     (ram_block)
    );

    AST_PD_STOPS_TICK: assert property (@(posedge clk) disable iff (!por_n)
        (in_pd && !rst_pin) |-> !mcyc_tick);  // R7

endmodule

// File: tb/sim_pwrmode_ctrl.sv
module sim_pwrmode_ctrl;
    localparam int NI = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin = 1'b0, pcon_wr = 1'b0, pcon_idle_req = 1'b0, pcon_pd_req = 1'b0;
    logic [NI-1:0] irq_pend = '0;
    logic core_rst, cpu_ce, per_ce, osc_run, port_force_hi, mcyc_tick;
    logic ram_wr_block, idle_bit, pd_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwrmode_ctrl #(.N_IRQ(NI)) u0 (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .pcon_wr(pcon_wr),
        .pcon_idle_req(pcon_idle_req), .pcon_pd_req(pcon_pd_req),
        .irq_pend(irq_pend), .core_rst(core_rst), .cpu_ce(cpu_ce),
        .per_ce(per_ce), .osc_run(osc_run), .port_force_hi(port_force_hi),
        .mcyc_tick(mcyc_tick), .ram_wr_block(ram_wr_block),
        .idle_bit(idle_bit), .pd_bit(pd_bit)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic steps(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pcon_write(input logic idl, input logic pd);
        pcon_wr = 1'b1; pcon_idle_req = idl; pcon_pd_req = pd;
        steps(1);
        pcon_wr = 1'b0; pcon_idle_req = 1'b0; pcon_pd_req = 1'b0;
    endtask

    task automatic count_ticks(input int n, output int cnt, output int bad_gap);
        int last;
        last = -1; cnt = 0; bad_gap = 0;
        for (int i = 0; i < n; i++) begin
            if (mcyc_tick) begin
                if (last >= 0 && i - last != 12) bad_gap++;
                last = i; cnt++;
            end
            steps(1);
        end
    endtask

    task automatic t_reset_state;
        int c, g;
        chk("R1 reset core_rst", core_rst, 0);
        chk("R1 reset cpu_ce", cpu_ce, 1);
        chk("R1 reset osc_run", osc_run, 1);
        chk("R3 reset port_force_hi", port_force_hi, 0);
        count_ticks(120, c, g);
        chk("R1 tick count in 120 clocks", c, 10);
        chk("R1 tick spacing", g, 0);
    endtask

    task automatic t_qual;
        rst_pin = 1'b1; #1;
        chk("R3 port_force_hi immediate", port_force_hi, 1);
        steps(20);
        rst_pin = 1'b0;
        steps(1);
        chk("R2 short pulse no reset", core_rst, 0);
        rst_pin = 1'b1;
        steps(23);
        chk("R2 no reset at 23 edges", core_rst, 0);
        steps(1);
        chk("R2 reset at 24th edge", core_rst, 1);
        chk("R3 ports high during reset", port_force_hi, 1);
        chk("R12 cpu_ce low in reset", cpu_ce, 0);
        pcon_write(1'b0, 1'b1);
        chk("R12 pd write ignored in reset", pd_bit, 0);
        pcon_write(1'b1, 1'b0);
        chk("R12 idle write ignored in reset", idle_bit, 0);
        rst_pin = 1'b0;
        steps(1);
        chk("R4 release core_rst", core_rst, 0);
        chk("R4 release port_force_hi", port_force_hi, 0);
        chk("R4 cpu_ce after release", cpu_ce, 1);
    endtask

    task automatic t_idle_irq;
        int c, g;
        irq_pend = 4'b0010;
        steps(2);
        chk("R6 irq in run no mode change", idle_bit, 0);
        irq_pend = '0;
        pcon_write(1'b1, 1'b0);
        chk("R5 idle_bit set", idle_bit, 1);
        chk("R5 cpu_ce off", cpu_ce, 0);
        chk("R5 per_ce on", per_ce, 1);
        count_ticks(24, c, g);
        chk("R5 ticks during idle", c, 2);
        irq_pend = 4'b1000;
        steps(1);
        chk("R6 idle cleared by irq", idle_bit, 0);
        chk("R6 cpu_ce back", cpu_ce, 1);
        chk("R6 no ram block on irq exit", ram_wr_block, 0);
        irq_pend = '0;
    endtask

    task automatic pd_reset_exit(input string tag);
        rst_pin = 1'b1; #1;
        chk({tag, " R9 osc restarts on pin"}, osc_run, 1);
        steps(23);
        chk({tag, " R9 pd held before reset"}, pd_bit, 1);
        chk({tag, " R2 no reset at 23"}, core_rst, 0);
        steps(1);
        chk({tag, " R9 reset asserted"}, core_rst, 1);
        steps(1);
        chk({tag, " R9 pd cleared by reset"}, pd_bit, 0);
        rst_pin = 1'b0;
        steps(1);
        chk({tag, " R9 cpu_ce after exit"}, cpu_ce, 1);
    endtask

    task automatic t_pdown;
        int c, g;
        pcon_write(1'b0, 1'b1);
        chk("R7 pd_bit set", pd_bit, 1);
        chk("R7 osc_run off", osc_run, 0);
        chk("R7 cpu_ce off", cpu_ce, 0);
        chk("R7 per_ce off", per_ce, 0);
        count_ticks(30, c, g);
        chk("R7 no ticks in pd", c, 0);
        irq_pend = '1;
        steps(5);
        chk("R8 pd kept with irq", pd_bit, 1);
        chk("R8 osc stays off with irq", osc_run, 0);
        irq_pend = '0;
        pd_reset_exit("pd");
    endtask

    task automatic t_both;
        pcon_write(1'b1, 1'b1);
        chk("R10 pd wins", pd_bit, 1);
        chk("R10 idle not set", idle_bit, 0);
        pd_reset_exit("both");
    endtask

    task automatic t_idle_rst;
        pcon_write(1'b1, 1'b0);
        chk("R11 in idle", idle_bit, 1);
        rst_pin = 1'b1;
        steps(1);
        chk("R11 idle left on pin", idle_bit, 0);
        chk("R11 cpu runs in window", cpu_ce, 1);
        chk("R11 ram block in window", ram_wr_block, 1);
        steps(22);
        chk("R11 window still open", ram_wr_block, 1);
        chk("R11 no reset yet", core_rst, 0);
        steps(1);
        chk("R11 reset takes hold", core_rst, 1);
        chk("R11 cpu stopped by reset", cpu_ce, 0);
        steps(1);
        chk("R11 ram block cleared", ram_wr_block, 0);
        rst_pin = 1'b0;
        steps(1);
    endtask

    initial begin
        steps(3);
        por_n = 1'b1;
        t_reset_state();
        t_qual();
        t_idle_irq();
        t_pdown();
        t_both();
        t_idle_rst();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule